// File: doc/BRIEF.md
# Down-counting interval timer

A 32-bit interval timer with a small register-mapped write/read port. A down-counter advances by one on each tick of a selectable source. Three tick inputs share the block clock and act as clock enables. When the count reaches zero it either reloads from a load register or wraps to all ones. A copy of the load value can also be forced into the counter when the timer is switched on, or on every write to the load register.

A compare register is checked against the count on every tick. A match sets a sticky event flag, which software clears by writing one to it, and which drives an interrupt output when the interrupt is enabled. Three low-power and debug mode inputs suspend counting unless the matching run bit in the control register allows it. A software reset bit clears the timer state. It reads back as one for a short time and then clears itself.

Used as a periodic source, the timer reloads at zero and interrupts once per period. Used as a one-shot, software disables it after the first event. Used as a free-running timebase, it wraps through the full 32-bit range and software reads the counter.

Top module: `dcount_timer`

## Requirements
- R1: Registers are at byte offsets 0x00 control, 0x04 status, 0x08 load, 0x0C compare and 0x10 counter, and each is 32 bits wide. Any other offset reads zero, and writes to the counter offset are ignored. After reset, control, status and compare read 0, and load and counter read 0xFFFFFFFF.
- R2: Control bits 25:24 choose the tick source. Code 0 selects no source, so the counter holds. Codes 1, 2 and 3 select tick_i[0], tick_i[1] and tick_i[2], and ticks on the other inputs have no effect.
- R3: While control bit 0 (enable) is 1, the counter drops by one on each selected tick. While it is 0, the counter holds its value.
- R4: On a tick at count 0, the counter takes the load register value when control bit 3 is 1, and becomes 0xFFFFFFFF when bit 3 is 0.
- R5: When control bit 1 is 1, a control write that takes bit 0 from 0 to 1 copies the load register into the counter in that cycle, and no tick is applied.
- R6: When control bit 17 is 1, a write to the load register writes the same value into the counter. When bit 17 is 0, the counter is left alone.
- R7: Status bit 0 becomes 1 after a tick on which the counter equalled the compare register.
- R8: Writing 1 to status bit 0 clears it, and writing 0 has no effect. A compare match in the same cycle as a clearing write leaves the bit at 1.
- R9: irq_o is high exactly when status bit 0 and control bit 2 are both 1.
- R10: While stop_mode_i, wait_mode_i or dbg_mode_i is high, ticks are ignored unless control bit 21, 19 or 18 (in that order) is 1.
- R11: A control write with bit 16 set clears every other control bit and the status flag, and sets the counter to 0xFFFFFFFF. Bit 16 then reads 1 for SWR_CYCLES cycles and clears itself, and control writes made during that time are ignored.
- R12: In one-shot use with a load of 2, compare 0 and reload at zero, three ticks after enabling produce exactly one event, and no more events follow once the timer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 5 | Register byte offset |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| tick_i | input | 3 | Tick enables for the three sources |
| stop_mode_i | input | 1 | Stop mode active |
| wait_mode_i | input | 1 | Wait mode active |
| dbg_mode_i | input | 1 | Debug mode active |
| irq_o | output | 1 | Compare interrupt |

## Verification
A compare match and a software write that clears the status flag can land in the same cycle. To test this, the bench sets the compare register to the current count, then applies a clearing status write together with a tick on the same clock edge. The flag must read 1 afterwards, because the new event has priority over the clear. A second collision is a load-register write that overwrites the counter while a tick is pending. Random stimulus covers it, and every cycle the result is compared against the bench's reference model.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_LOAD = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CMP  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 5'h10;

  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_ENLD = 1;
  localparam int unsigned B_IE   = 2;
  localparam int unsigned B_RLD  = 3;
  localparam int unsigned B_SWR  = 16;
  localparam int unsigned B_OVW  = 17;
  localparam int unsigned B_DBG  = 18;
  localparam int unsigned B_WAIT = 19;
  localparam int unsigned B_STOP = 21;
  localparam int unsigned B_SRC  = 24;

  localparam logic [REG_W-1:0] CTRL_WMASK = 32'h032E_000F;

  typedef struct packed {
    logic swr_start;
    logic en_load;
    logic cnt_ovw;
    logic flag_clr;
  } dct_cmd_t;
endpackage

// File: rtl/dct_tick_gate.sv
module dct_tick_gate #(
  parameter int unsigned N_SRC = 3,
  localparam int unsigned SEL_W = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  input  logic             stop_mode_i,
  input  logic             wait_mode_i,
  input  logic             dbg_mode_i,
  input  logic             run_stop_i,
  input  logic             run_wait_i,
  input  logic             run_dbg_i,
  output logic             step_o
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = tick_i[g] && (sel_i == SEL_W'(g + 1));
  end

  logic mode_ok;
  assign mode_ok = (!stop_mode_i || run_stop_i) &&
                   (!wait_mode_i || run_wait_i) &&
                   (!dbg_mode_i  || run_dbg_i);

  assign step_o = en_i && mode_ok && (|hit);
endmodule

// File: rtl/dct_regs.sv
module dct_regs
  import dct_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned SWR_CYCLES = 2,
  localparam int unsigned SWR_W = $clog2(SWR_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  ctrl_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  load_o,
  output logic [CNT_W-1:0]  cmp_o,
  output dct_cmd_t          cmd_o
);
  logic [REG_W-1:0] ctrl_q;
  logic [SWR_W-1:0] swr_left_q;
  logic ctrl_acc;

  assign busy_o   = (swr_left_q != '0);
  assign ctrl_acc = we_i && (addr_i == OFF_CTRL) && !busy_o;

  assign cmd_o.swr_start = ctrl_acc && wdata_i[B_SWR];
  assign cmd_o.en_load   = ctrl_acc && !wdata_i[B_SWR] && wdata_i[B_EN] &&
                           !ctrl_q[B_EN] && wdata_i[B_ENLD];
  assign cmd_o.cnt_ovw   = we_i && (addr_i == OFF_LOAD) && ctrl_q[B_OVW];
  assign cmd_o.flag_clr  = we_i && (addr_i == OFF_STAT) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      swr_left_q <= '0;
    end else if (cmd_o.swr_start) begin
      ctrl_q     <= '0;
      swr_left_q <= SWR_W'(SWR_CYCLES);
    end else begin
      if (ctrl_acc) ctrl_q <= wdata_i & CTRL_WMASK;
      if (busy_o) swr_left_q <= swr_left_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o <= '1;
      cmp_o  <= '0;
    end else if (we_i) begin
      if (addr_i == OFF_LOAD) load_o <= wdata_i[CNT_W-1:0];
      if (addr_i == OFF_CMP)  cmp_o  <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    ctrl_o = ctrl_q;
    ctrl_o[B_SWR] = busy_o;
  end
endmodule

// File: rtl/dct_down_counter.sv
module dct_down_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             rld_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             swr_i,
  input  logic             en_load_i,
  input  logic             ovw_i,
  input  logic [CNT_W-1:0] ovw_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_d;
  logic at_zero;

  assign at_zero = (cnt_o == '0);
  assign hit_o   = step_i && (cnt_o == cmp_i);

  // priority: soft reset, enable reload, overwrite, tick
  always_comb begin
    cnt_d = cnt_o;
    if (swr_i)            cnt_d = '1;
    else if (en_load_i)   cnt_d = load_i;
    else if (ovw_i)       cnt_d = ovw_val_i;
    else if (step_i) begin
      if (!at_zero)       cnt_d = cnt_o - 1'b1;
      else if (rld_i)     cnt_d = load_i;
      else                cnt_d = '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '1;
    else         cnt_o <= cnt_d;
  end
endmodule

// File: rtl/dct_status.sv
module dct_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic swr_i,
  input  logic hit_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (swr_i)  flag_o <= 1'b0;
    else if (hit_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  assign irq_o = flag_o && ie_i;
endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
  import dct_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N_SRC = 3,
  parameter int unsigned SWR_CYCLES = 2,
  localparam int unsigned SEL_W = $clog2(N_SRC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic [N_SRC-1:0]  tick_i,
  input  logic              stop_mode_i,
  input  logic              wait_mode_i,
  input  logic              dbg_mode_i,
  output logic              irq_o
);
  logic [REG_W-1:0] ctrl_rd;
  logic             swr_busy;
  logic [CNT_W-1:0] load_q, cmp_q, cnt_q;
  dct_cmd_t         cmd;
  logic             step, cmp_hit, flag_q;

  dct_regs #(.CNT_W(CNT_W), .SWR_CYCLES(SWR_CYCLES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (bus_addr_i),
    .we_i    (bus_we_i),
    .wdata_i (bus_wdata_i),
    .ctrl_o  (ctrl_rd),
    .busy_o  (swr_busy),
    .load_o  (load_q),
    .cmp_o   (cmp_q),
    .cmd_o   (cmd)
  );

  dct_tick_gate #(.N_SRC(N_SRC)) u_gate (
    .tick_i      (tick_i),
    .sel_i       (ctrl_rd[B_SRC +: SEL_W]),
    .en_i        (ctrl_rd[B_EN]),
    .stop_mode_i (stop_mode_i),
    .wait_mode_i (wait_mode_i),
    .dbg_mode_i  (dbg_mode_i),
    .run_stop_i  (ctrl_rd[B_STOP]),
    .run_wait_i  (ctrl_rd[B_WAIT]),
    .run_dbg_i   (ctrl_rd[B_DBG]),
    .step_o      (step)
  );

  dct_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .rld_i     (ctrl_rd[B_RLD]),
    .load_i    (load_q),
    .cmp_i     (cmp_q),
    .swr_i     (cmd.swr_start),
    .en_load_i (cmd.en_load),
    .ovw_i     (cmd.cnt_ovw),
    .ovw_val_i (bus_wdata_i[CNT_W-1:0]),
    .cnt_o     (cnt_q),
    .hit_o     (cmp_hit)
  );

  dct_status u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .swr_i  (cmd.swr_start),
    .hit_i  (cmp_hit),
    .clr_i  (cmd.flag_clr),
    .ie_i   (ctrl_rd[B_IE]),
    .flag_o (flag_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFF_CTRL: bus_rdata_o = ctrl_rd;
      OFF_STAT: bus_rdata_o[0] = flag_q;
      OFF_LOAD: bus_rdata_o[CNT_W-1:0] = load_q;
      OFF_CMP:  bus_rdata_o[CNT_W-1:0] = cmp_q;
      OFF_CNT:  bus_rdata_o[CNT_W-1:0] = cnt_q;
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dcount_timer_chk.sv
module dcount_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [4:0]       bus_addr_i,
  input logic             bus_we_i,
  input logic             wd0,
  input logic             stop_mode_i,
  input logic             irq_o,
  input logic [31:0]      ctrl_rd,
  input logic             swr_busy,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] load_q,
  input logic             step,
  input logic             cmp_hit,
  input logic             flag_q
);
  p_src_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd[25:24] == 2'd0) |-> !step);

  p_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_we_i && !ctrl_rd[0]) |=> $stable(cnt_q));

  p_step_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && cnt_q != '0 && !bus_we_i) |=> cnt_q == $past(cnt_q) - 1'b1);

  p_zero_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && cnt_q == '0 && ctrl_rd[3] && !bus_we_i) |=> cnt_q == $past(load_q));

  p_zero_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && cnt_q == '0 && !ctrl_rd[3] && !bus_we_i) |=> (&cnt_q));

  p_hit_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_hit && !bus_we_i) |=> flag_q);

  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !cmp_hit && bus_we_i && bus_addr_i == 5'h04 && wd0) |=> !flag_q);

  p_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_q && ctrl_rd[2]));

  p_stop_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_mode_i && !ctrl_rd[21]) |-> !step);

  p_swr_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(swr_busy) |-> (ctrl_rd == 32'h0001_0000 && (&cnt_q) && !flag_q));
endmodule

bind dcount_timer dcount_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_we_i    (bus_we_i),
  .wd0         (bus_wdata_i[0]),
  .stop_mode_i (stop_mode_i),
  .irq_o       (irq_o),
  .ctrl_rd     (ctrl_rd),
  .swr_busy    (swr_busy),
  .cnt_q       (cnt_q),
  .load_q      (load_q),
  .step        (step),
  .cmp_hit     (cmp_hit),
  .flag_q      (flag_q)
);

// File: tb/dcount_timer_bench.sv
`timescale 1ns/1ps
module dcount_timer_bench;
  localparam int SWR = 2;
  localparam logic [31:0] MASK = 32'h032E_000F;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [4:0] addr = 5'h00;
  logic we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0] tick = '0;
  logic stop_m = 1'b0, wait_m = 1'b0, dbg_m = 1'b0;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dcount_timer u_dcount_timer (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_i(tick),
    .stop_mode_i(stop_m), .wait_mode_i(wait_m), .dbg_mode_i(dbg_m), .irq_o(irq)
  );

  // reference model
  logic [31:0] m_ctrl, m_load, m_cmp, m_cnt;
  logic m_flag;
  int m_busy;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = 0; m_load = '1; m_cmp = 0; m_cnt = '1; m_flag = 0; m_busy = 0;
    end else begin
      logic [1:0] sel;
      logic st, hit, cw, sw, enl, ov, nf;
      logic [31:0] nc, nctl;
      int nb;
      sel = m_ctrl[25:24];
      st = (m_busy == 0) && m_ctrl[0] && (sel != 0) && tick[sel - 2'd1]
           && (!stop_m || m_ctrl[21]) && (!wait_m || m_ctrl[19]) && (!dbg_m || m_ctrl[18]);
      hit = st && (m_cnt == m_cmp);
      cw = we && addr == 5'h00 && m_busy == 0;
      sw = cw && wdata[16];
      enl = cw && !sw && wdata[0] && !m_ctrl[0] && wdata[1];
      ov = we && addr == 5'h08 && m_ctrl[17];
      nc = m_cnt;
      if (sw) nc = '1;
      else if (enl) nc = m_load;
      else if (ov) nc = wdata;
      else if (st) nc = (m_cnt == 0) ? (m_ctrl[3] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1;
      nf = m_flag;
      if (sw) nf = 0;
      else if (hit) nf = 1;
      else if (we && addr == 5'h04 && wdata[0]) nf = 0;
      nctl = m_ctrl;
      nb = m_busy;
      if (sw) begin nctl = 0; nb = SWR; end
      else begin
        if (cw) nctl = wdata & MASK;
        if (nb > 0) nb = nb - 1;
      end
      if (we && addr == 5'h08) m_load = wdata;
      if (we && addr == 5'h0C) m_cmp = wdata;
      m_cnt = nc; m_flag = nf; m_ctrl = nctl; m_busy = nb;
    end
  end

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return m_ctrl | ((m_busy > 0) ? 32'h0001_0000 : 32'h0);
      5'h04: return {31'h0, m_flag};
      5'h08: return m_load;
      5'h0C: return m_cmp;
      5'h10: return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'h00: return "R11";
      5'h04: return "R7";
      5'h10: return "R3";
      default: return "R1";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      checks++;
      if (rdata !== m_read(addr)) begin
        fails++;
        $display("FAIL %s model addr=%h actual=%h expected=%h", tag_of(addr), addr, rdata, m_read(addr));
      end
      checks++;
      if (irq !== (m_flag && m_ctrl[2])) begin
        fails++;
        $display("FAIL R9 model irq actual=%b expected=%b", irq, m_flag && m_ctrl[2]);
      end
    end
  end

  int ev_cnt = 0;
  logic irq_prev = 1'b0;
  always @(negedge clk) begin
    if (irq && !irq_prev) ev_cnt++;
    irq_prev = irq;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1 addr = a; we = 1'b1; wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic wr_tick(input logic [4:0] a, input logic [31:0] d, input logic [2:0] t);
    @(posedge clk); #1 addr = a; we = 1'b1; wdata = d; tick = t;
    @(posedge clk); #1 we = 1'b0; tick = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string r);
    @(posedge clk); #1 addr = a;
    @(negedge clk); chk(r, rdata, exp);
  endtask

  task automatic ticks(input logic [2:0] p, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick = p;
    end
    @(posedge clk); #1 tick = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset values
    rd(5'h00, 32'h0, "R1");
    rd(5'h04, 32'h0, "R1");
    rd(5'h08, 32'hFFFF_FFFF, "R1");
    rd(5'h0C, 32'h0, "R1");
    rd(5'h10, 32'hFFFF_FFFF, "R1");
    rd(5'h14, 32'h0, "R1");
    wr(5'h08, 32'h20); rd(5'h08, 32'h20, "R1");
    wr(5'h0C, 32'h1C); rd(5'h0C, 32'h1C, "R1");
    wr(5'h10, 32'h1234); rd(5'h10, 32'hFFFF_FFFF, "R1");

    // R2/R3 source 1 counting
    wr(5'h00, 32'h0100_0001);
    ticks(3'b001, 5); rd(5'h10, 32'hFFFF_FFFA, "R3");
    ticks(3'b110, 4); rd(5'h10, 32'hFFFF_FFFA, "R2");
    wr(5'h00, 32'h0200_0001);
    ticks(3'b010, 4); rd(5'h10, 32'hFFFF_FFF6, "R2");
    wr(5'h00, 32'h0000_0001);
    ticks(3'b111, 3); rd(5'h10, 32'hFFFF_FFF6, "R2");
    // R3 freeze with enable clear
    wr(5'h00, 32'h0100_0000);
    ticks(3'b001, 3); rd(5'h10, 32'hFFFF_FFF6, "R3");

    // R5 reload on enable
    wr(5'h08, 32'h5);
    wr(5'h00, 32'h0100_0003); rd(5'h10, 32'h5, "R5");
    // R4 wrap without reload
    ticks(3'b001, 5); rd(5'h10, 32'h0, "R4");
    ticks(3'b001, 1); rd(5'h10, 32'hFFFF_FFFF, "R4");
    // R4 reload at zero
    wr(5'h00, 32'h0100_0000);
    wr(5'h08, 32'h3);
    wr(5'h00, 32'h0100_000B); rd(5'h10, 32'h3, "R5");
    ticks(3'b001, 4); rd(5'h10, 32'h3, "R4");

    // R6 overwrite
    wr(5'h00, 32'h0102_0009);
    wr(5'h08, 32'h777); rd(5'h10, 32'h777, "R6");
    wr(5'h00, 32'h0100_0009);
    wr(5'h08, 32'h55); rd(5'h10, 32'h777, "R6");

    // R7 compare
    wr(5'h0C, 32'h770);
    ticks(3'b001, 7); rd(5'h04, 32'h0, "R7");
    ticks(3'b001, 1); rd(5'h04, 32'h1, "R7");
    @(negedge clk); chk("R9", {31'h0, irq}, 32'h0);
    wr(5'h00, 32'h0100_000D);
    @(negedge clk); chk("R9", {31'h0, irq}, 32'h1);
    // R8 write-one-to-clear
    wr(5'h04, 32'h0); rd(5'h04, 32'h1, "R8");
    wr(5'h04, 32'h1); rd(5'h04, 32'h0, "R8");
    @(negedge clk); chk("R9", {31'h0, irq}, 32'h0);
    // R8 event beats clear in the same cycle
    wr(5'h0C, 32'h76F);
    wr_tick(5'h04, 32'h1, 3'b001); rd(5'h04, 32'h1, "R8");
    wr(5'h04, 32'h1);
    rd(5'h10, 32'h76E, "R3");

    // R10 mode gating, each mode in turn
    for (int m = 0; m < 3; m++) begin
      logic [31:0] run_bit;
      run_bit = (m == 0) ? 32'h0020_0000 : (m == 1) ? 32'h0008_0000 : 32'h0004_0000;
      wr(5'h00, 32'h0100_0009);
      wr(5'h08, 32'h100);
      wr(5'h00, 32'h0100_0008);
      wr(5'h00, 32'h0100_000B);
      @(posedge clk); #1 stop_m = (m == 0); wait_m = (m == 1); dbg_m = (m == 2);
      ticks(3'b001, 3); rd(5'h10, 32'h100, "R10");
      wr(5'h00, 32'h0100_0009 | run_bit);
      ticks(3'b001, 3); rd(5'h10, 32'hFD, "R10");
      @(posedge clk); #1 stop_m = 0; wait_m = 0; dbg_m = 0;
    end

    // R12 one-shot with load 2
    wr(5'h00, 32'h0100_0000);
    wr(5'h04, 32'h1);
    wr(5'h0C, 32'h0);
    wr(5'h08, 32'h2);
    wr(5'h00, 32'h0100_000F);
    ev_cnt = 0;
    ticks(3'b001, 3);
    wr(5'h00, 32'h0100_0004);
    rd(5'h10, 32'h2, "R12");
    ticks(3'b001, 6);
    chk("R12", ev_cnt, 1);

    // R11 soft reset
    wr(5'h00, 32'h0101_000F);
    @(negedge clk); chk("R11", rdata, 32'h0001_0000);
    wr(5'h00, 32'h0100_0001);
    rd(5'h10, 32'hFFFF_FFFF, "R11");
    rd(5'h04, 32'h0, "R11");
    rd(5'h00, 32'h0, "R11");

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      tick = 3'($urandom);
      stop_m = ($urandom % 8) == 0;
      wait_m = ($urandom % 8) == 0;
      dbg_m = ($urandom % 8) == 0;
      addr = 5'(4 * ($urandom % 6));
      we = ($urandom % 4) == 0;
      wdata = $urandom;
      if (addr == 5'h00) wdata = wdata & ~(($urandom % 8 != 0) ? 32'h0001_0000 : 32'h0);
      if (addr == 5'h08 || addr == 5'h0C) wdata = wdata & 32'h3F;
    end
    @(posedge clk); #1 we = 1'b0; tick = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule